// File: doc/BRIEF.md
# Cellular-Automaton Check-Byte Encoder

This block is a streaming systematic encoder for a block code with 28 information bytes and 4 check bytes per 32-byte codeword. Information bytes arrive one per cycle with a valid strobe. The first byte of each block also carries a start marker. Every byte is forwarded unchanged on the output in the same cycle, so the information part of the codeword needs no buffering.

In parallel, the block keeps four 8-bit accumulators. Accumulator `a` is updated in Horner form: it is XORed with the incoming byte and the result is then passed through the `a`-th power of the next-state map of an 8-cell hybrid cellular automaton. That automaton has null boundaries, uses rules 90 and 150, and has maximum length. The arithmetic is plain XOR networks; there are no Galois-field multipliers.

After the last information byte, the four check bytes appear together on a parallel output with a done flag. They stay there until the next block starts. The surrounding logic appends them to the stream as C0, C1, C2, C3.

Top module: `ca_check_encoder`

## Requirements
- R1: `out_valid` and `out_data` equal `in_valid` and `in_data` in the same cycle, for every byte.
- R2: The operator T maps state q to q' where q'[i] = q[i-1] ^ q[i+1], plus q[i] if cell i uses rule 150. Bits beyond 0 and 7 read as 0. Cells 0,1,3,5,7 use rule 150 and cells 2,4,6 use rule 90.
- R3: With bytes D0..D(N-1) accepted in order, `chk_o[8a+7:8a]` holds Ca, the XOR over k of T^(a·(N−k)) applied to Dk, for a = 0..3. So D(N-1) is multiplied by T^a and D0 by T^(N·a).
- R4: C0 (`chk_o[7:0]`) equals the plain XOR of all N information bytes.
- R5: `blk_done` rises in the cycle after the N-th byte is accepted. While no new start arrives, `blk_done` and `chk_o` then stay constant.
- R6: A byte with `in_valid` and `in_sob` both high becomes D0 of a new block. Any partial or finished earlier block is discarded and `blk_done` falls in the next cycle.
- R7: Valid bytes without `in_sob` are ignored when they arrive before any start or after the N-th byte of a block.
- R8: Cycles with `in_valid` low change nothing, whatever `in_sob` and `in_data` carry.
- R9: After reset, and whenever `blk_done` is low, `chk_o` reads zero.
- R10: A block of all-zero information bytes yields four zero check bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Information byte present |
| in_sob | input | 1 | Start of block; qualified by `in_valid` |
| in_data | input | 8 | Information byte |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded information byte |
| blk_done | output | 1 | Check bytes of the last block are ready |
| chk_o | output | 32 | Check bytes, C0 in bits 7:0 up to C3 in bits 31:24 |

## Verification
The hardest situation to reach from the ports is a block that was abandoned part-way and restarted. In that case the accumulators hold non-zero values when the new start marker arrives, and they must be overwritten rather than folded in. The stimulus first sends a random partial block, then a fresh start with a full block, and compares the result only against the second block. Random idle cycles carrying junk data and stray start markers are mixed into the blocks. Further valid bytes are sent before the first start and after completion, to show they leave the held check bytes untouched.

// File: rtl/ca_check_encoder.sv
module ca_check_encoder #(
  parameter int N_INFO = 28,
  parameter int W = 8,
  parameter int NCHK = 4,
  parameter logic [W-1:0] RULE150 = 8'b1010_1011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sob,
  input  logic [W-1:0]    in_data,
  output logic            out_valid,
  output logic [W-1:0]    out_data,
  output logic            blk_done,
  output logic [NCHK*W-1:0] chk_o
);

  localparam int CW = $clog2(N_INFO + 1);

  function automatic logic [W-1:0] ca_pow(input logic [W-1:0] q, input int p);
    logic [W-1:0] s;
    s = q;
    for (int i = 0; i < p; i++)
      s = (s << 1) ^ (s >> 1) ^ (s & RULE150);
    return s;
  endfunction

  logic [CW-1:0] cnt;
  logic [W-1:0]  acc [NCHK];

  wire take_first = in_valid & in_sob;
  wire take_next  = in_valid & ~in_sob & (cnt != '0) & (cnt < CW'(N_INFO));

  assign out_valid = in_valid;
  assign out_data  = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      blk_done <= 1'b0;
    end else if (take_first) begin
      cnt      <= CW'(1);
      blk_done <= (N_INFO == 1);
    end else if (take_next) begin
      cnt      <= cnt + CW'(1);
      blk_done <= (cnt == CW'(N_INFO - 1));
    end
  end

  for (genvar a = 0; a < NCHK; a++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc[a] <= '0;
      else if (take_first) acc[a] <= ca_pow(in_data, a);
      else if (take_next)  acc[a] <= ca_pow(acc[a] ^ in_data, a);
    end
    assign chk_o[a*W +: W] = blk_done ? acc[a] : '0;
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(N_INFO));

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && !take_first |=> blk_done && $stable(chk_o));

  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_done) |-> $past(in_valid));

  p_sob_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_first && (N_INFO > 1) |=> !blk_done);

  p_idle_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(chk_o) && $stable(blk_done) && $stable(cnt));

  p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |-> chk_o == '0);

endmodule

// File: tb/ca_check_encoder_tb.sv
`timescale 1ns/1ps
module ca_check_encoder_tb;
  localparam int N = 28;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sob = 0;
  logic [7:0] in_data = 0;
  logic out_valid, blk_done;
  logic [7:0] out_data;
  logic [31:0] chk_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] blk [N];

  ca_check_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .blk_done(blk_done), .chk_o(chk_o));

  always #10 clk = ~clk;

  function automatic logic [7:0] step(input logic [7:0] q);
    int rules [8] = '{150, 150, 90, 150, 90, 150, 90, 150};
    logic [7:0] n;
    for (int i = 0; i < 8; i++) begin
      logic l, r;
      l = (i > 0) ? q[i-1] : 1'b0;
      r = (i < 7) ? q[i+1] : 1'b0;
      n[i] = l ^ r ^ ((rules[i] == 150) ? q[i] : 1'b0);
    end
    return n;
  endfunction

  function automatic logic [7:0] model(input int a);
    logic [7:0] acc = 0;
    for (int k = 0; k < N; k++) begin
      logic [7:0] t = blk[k];
      for (int r = 0; r < a * (N - k); r++) t = step(t);
      acc ^= t;
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] d, input bit v, input bit s);
    @(negedge clk);
    in_valid = v; in_sob = s; in_data = d;
    #1;
    check(out_valid == v && out_data == d, "R1 passthrough", {23'd0, out_valid, out_data}, {23'd0, v, d});
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 0; in_sob = 0; in_data = 8'h5A;
    #1;
  endtask

  task automatic send_block(input bit gaps);
    for (int k = 0; k < N; k++) begin
      drive(blk[k], 1, k == 0);
      if (k == 5) check(!blk_done && chk_o == 0, "R9 zero while busy", chk_o, 0);
      if (gaps && ($urandom % 4 == 0)) drive(8'($urandom), 0, 1'($urandom));
    end
    settle();
  endtask

  task automatic check_result(input string tag);
    logic [7:0] x = 0;
    for (int k = 0; k < N; k++) x ^= blk[k];
    check(blk_done, {tag, " R5 done"}, {31'd0, blk_done}, 1);
    check(chk_o[7:0] == x, {tag, " R4 C0 parity"}, chk_o[7:0], x);
    for (int a = 0; a < 4; a++)
      check(chk_o[8*a +: 8] == model(a), {tag, " R3 R2 check byte"}, chk_o[8*a +: 8], model(a));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!blk_done && chk_o == 0, "R9 reset state", chk_o, 0);

    // R7: bytes before any start are ignored
    for (int j = 0; j < 3; j++) drive(8'($urandom) | 8'h01, 1, 0);
    settle();
    check(!blk_done && chk_o == 0, "R7 before start", chk_o, 0);

    // R10: all-zero block
    for (int k = 0; k < N; k++) blk[k] = 0;
    send_block(0);
    check_result("R10 zero block");
    check(chk_o == 0, "R10 all zero", chk_o, 0);

    // single nonzero byte at each end
    for (int k = 0; k < N; k++) blk[k] = 0;
    blk[0] = 8'h01;
    send_block(0);
    check_result("first byte only");
    for (int k = 0; k < N; k++) blk[k] = 0;
    blk[N-1] = 8'h80;
    send_block(0);
    check_result("last byte only");

    // random blocks, some with idle gaps (R8)
    for (int b = 0; b < 20; b++) begin
      for (int k = 0; k < N; k++) blk[k] = 8'($urandom);
      send_block(b % 2 == 1);
      check_result((b % 2 == 1) ? "R8 random gaps" : "random");
    end

    // R7: valid bytes after completion leave result unchanged
    held = chk_o;
    for (int j = 0; j < 5; j++) drive(8'($urandom) | 8'h10, 1, 0);
    settle();
    check(blk_done && chk_o == held, "R7 after done", chk_o, held);

    // R6: restart mid-block
    drive(8'hC3, 1, 1);
    settle();
    check(!blk_done, "R6 done falls", {31'd0, blk_done}, 0);
    for (int j = 0; j < 10; j++) drive(8'($urandom), 1, 0);
    for (int k = 0; k < N; k++) blk[k] = 8'($urandom);
    send_block(0);
    check_result("R6 restart");

    // R6: back-to-back blocks with no idle
    for (int k = 0; k < N; k++) blk[k] = 8'($urandom);
    for (int k = 0; k < N; k++) drive(blk[k], 1, k == 0);
    for (int k = 0; k < N; k++) blk[k] = 8'($urandom);
    send_block(0);
    check_result("R6 back to back");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule